// File: doc/BRIEF.md
# Four-core IRQ/FIQ interrupt steering unit

This unit takes interrupt requests from several kinds of source and presents them to four processor cores. Each core has a normal interrupt output and a fast interrupt output. The sources are:

- four timer lines per core;
- four mailbox-pending lines per core;
- one shared normal line and one shared fast line from an upstream controller;
- one local-timer request.

Each per-core source is steered by two enable bits in an 8-bit control register. The fast enable wins over the normal enable, and a source with neither enable set is masked. The shared upstream lines and the local-timer request are each delivered to a single core, chosen by a route field.

Software reaches the unit through a plain 32-bit word register port. Writes take effect at the clock edge on which they are sampled. A read strobe returns its data, together with a valid flag, one cycle later. Two banks of per-core source registers can be read to show which sources are currently asserting each output. These source registers are derived combinationally from the live input levels, so the core outputs follow input changes within the same cycle. The register port is a control path and has no back-pressure: every strobe is accepted.

Top module: `irq_steer_top`

## Requirements
- R1: After reset every route field and control register reads as zero, and the read data output is zero.
- R2: Timer line j of core c is `tmr_lvl[4c+j]`, and it is controlled by the register at byte offset 0x40+4c. Setting bit j+4 sends the line to the fast source register only. Otherwise, setting bit j sends it to the normal source register. With neither bit set the line is masked. The line appears at source bit j.
- R3: Mailbox line j of core c is `mbx_lvl[4c+j]`, and it is controlled by the register at 0x50+4c using the same bit rule as R2. The line appears at source bit 4+j.
- R4: The shared route register at 0x0C selects the core that receives `up_irq` in bits [1:0] and the core that receives `up_fiq` in bits [3:2]. Both appear at source bit 8 of the selected core. A read returns the two fields in those positions, with all other bits zero.
- R5: The local-timer route register at 0x24 keeps 3 bits. Bits [1:0] select the core. Bit 2 set sends `ltmr_req` to that core's fast source register, and bit 2 clear sends it to the normal one. The request appears at source bit 11.
- R6: The normal source register of core c reads at 0x60+4c and the fast one at 0x70+4c. Bits 9, 10 and 12 to 31 read zero, and writes to these offsets change nothing.
- R7: `core_irq[c]` is high exactly when core c's normal source register is non-zero, and `core_fiq[c]` exactly when its fast source register is non-zero, in the same cycle as the inputs.
- R8: Per-core control registers keep only bits [7:0]. The upper bits of a write are dropped and read back as zero.
- R9: Reads of unmapped or non-word-aligned offsets return zero, and writes to them change no state.
- R10: `reg_rd_valid` is high in exactly the cycle after a cycle with `reg_rd_en` high, and `reg_rdata` then holds the addressed value as it was at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rd_valid | output | 1 | Read data valid |
| tmr_lvl | input | 16 | Timer lines, core c line j at bit 4c+j |
| mbx_lvl | input | 16 | Mailbox-pending lines, core c mailbox j at bit 4c+j |
| up_irq | input | 1 | Shared upstream normal interrupt |
| up_fiq | input | 1 | Shared upstream fast interrupt |
| ltmr_req | input | 1 | Local-timer interrupt request |
| core_irq | output | 4 | Normal interrupt per core |
| core_fiq | output | 4 | Fast interrupt per core |

## Verification
The per-core steering is first exercised with all lines of one core high under the enable patterns normal-only, fast-only, both and neither. These separate the fast-wins priority from plain masking. Split patterns then give lines of the same core different destinations, which exposes swapped enable halves or swapped line indices. Route values for the shared and local-timer sources, chosen with different normal and fast targets, expose crossed fields and broadcasting. A long phase of mixed random input levels, control writes and reads, including offsets that are read-only, unmapped or misaligned, is compared every cycle against a behavioural model.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int N_TMR   = 4;
  localparam int N_MBX   = 4;
  localparam int CTL_W   = 2 * N_TMR;
  localparam int SRC_W   = 12;
  localparam int TMR_LSB = 0;
  localparam int MBX_LSB = N_TMR;
  localparam int UP_BIT  = 8;
  localparam int LT_BIT  = 11;

  localparam logic [ADDR_W-1:0] OFS_SHARED  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_LTROUTE = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TMRCTL  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MBXCTL  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_IRQSRC  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_FIQSRC  = 8'h70;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SHARED, SEL_LTROUTE, SEL_TMRCTL,
    SEL_MBXCTL, SEL_IRQSRC, SEL_FIQSRC
  } sel_e;

  typedef enum logic [1:0] {DST_MASK, DST_IRQ, DST_FIQ} dst_e;

  function automatic dst_e pick_dst(input logic irq_en, input logic fiq_en);
    if (fiq_en) return DST_FIQ;
    if (irq_en) return DST_IRQ;
    return DST_MASK;
  endfunction
endpackage

// File: rtl/irq_steer_core.sv
module irq_steer_core
  import irq_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] tmr_lvl,
  input  logic [N_MBX-1:0] mbx_lvl,
  input  logic [CTL_W-1:0] tmr_ctl,
  input  logic [CTL_W-1:0] mbx_ctl,
  input  logic             up_irq_hit,
  input  logic             up_fiq_hit,
  input  logic             lt_irq_hit,
  input  logic             lt_fiq_hit,
  output logic [SRC_W-1:0] irq_src,
  output logic [SRC_W-1:0] fiq_src,
  output logic             irq,
  output logic             fiq
);
  dst_e tmr_dst [N_TMR];
  dst_e mbx_dst [N_MBX];

  for (genvar j = 0; j < N_TMR; j++) begin : g_tmr
    assign tmr_dst[j] = pick_dst(tmr_ctl[j], tmr_ctl[N_TMR+j]);
  end
  for (genvar j = 0; j < N_MBX; j++) begin : g_mbx
    assign mbx_dst[j] = pick_dst(mbx_ctl[j], mbx_ctl[N_MBX+j]);
  end

  always_comb begin
    irq_src = '0;
    fiq_src = '0;
    for (int j = 0; j < N_TMR; j++) begin
      irq_src[TMR_LSB+j] = tmr_lvl[j] && (tmr_dst[j] == DST_IRQ);
      fiq_src[TMR_LSB+j] = tmr_lvl[j] && (tmr_dst[j] == DST_FIQ);
    end
    for (int j = 0; j < N_MBX; j++) begin
      irq_src[MBX_LSB+j] = mbx_lvl[j] && (mbx_dst[j] == DST_IRQ);
      fiq_src[MBX_LSB+j] = mbx_lvl[j] && (mbx_dst[j] == DST_FIQ);
    end
    irq_src[UP_BIT] = up_irq_hit;
    fiq_src[UP_BIT] = up_fiq_hit;
    irq_src[LT_BIT] = lt_irq_hit;
    fiq_src[LT_BIT] = lt_fiq_hit;
  end

  assign irq = |irq_src;
  assign fiq = |fiq_src;

  // R2
  one_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_src[MBX_LSB+N_MBX-1:0] & fiq_src[MBX_LSB+N_MBX-1:0]) == '0));
  // R3
  mbx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_lvl == '0) |-> (irq_src[MBX_LSB +: N_MBX] == '0 && fiq_src[MBX_LSB +: N_MBX] == '0));
  // R7
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_lvl == '0 && mbx_lvl == '0 && !up_irq_hit && !lt_irq_hit) |-> !irq);
endmodule

// File: rtl/irq_steer_fanout.sv
module irq_steer_fanout #(
  parameter int NUM_CORES = 4,
  parameter int CIDX_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_irq,
  input  logic                 up_fiq,
  input  logic                 ltmr_req,
  input  logic [CIDX_W-1:0]    up_irq_core,
  input  logic [CIDX_W-1:0]    up_fiq_core,
  input  logic [CIDX_W-1:0]    lt_core,
  input  logic                 lt_fiq,
  output logic [NUM_CORES-1:0] up_irq_hit,
  output logic [NUM_CORES-1:0] up_fiq_hit,
  output logic [NUM_CORES-1:0] lt_irq_hit,
  output logic [NUM_CORES-1:0] lt_fiq_hit
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam logic [CIDX_W-1:0] ME = CIDX_W'(c);
    assign up_irq_hit[c] = up_irq && (up_irq_core == ME);
    assign up_fiq_hit[c] = up_fiq && (up_fiq_core == ME);
    assign lt_irq_hit[c] = ltmr_req && !lt_fiq && (lt_core == ME);
    assign lt_fiq_hit[c] = ltmr_req && lt_fiq && (lt_core == ME);
  end

  // R5
  lt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ltmr_req |-> ($countones({lt_irq_hit, lt_fiq_hit}) == 1));
  // R5
  lt_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ltmr_req |-> ({lt_irq_hit, lt_fiq_hit} == '0));
  // R4
  up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_irq_hit) && $onehot0(up_fiq_hit));
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CIDX_W    = $clog2(NUM_CORES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rd_valid,
  input  logic [NUM_CORES-1:0][SRC_W-1:0]   irq_src_i,
  input  logic [NUM_CORES-1:0][SRC_W-1:0]   fiq_src_i,
  output logic [NUM_CORES-1:0][CTL_W-1:0]   tmr_ctl_o,
  output logic [NUM_CORES-1:0][CTL_W-1:0]   mbx_ctl_o,
  output logic [CIDX_W-1:0]                 up_irq_core_o,
  output logic [CIDX_W-1:0]                 up_fiq_core_o,
  output logic [CIDX_W-1:0]                 lt_core_o,
  output logic                              lt_fiq_o
);
  logic [NUM_CORES-1:0][CTL_W-1:0] tmr_ctl_q, mbx_ctl_q;
  logic [CIDX_W-1:0] up_irq_core_q, up_fiq_core_q, lt_core_q;
  logic              lt_fiq_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              rd_valid_q;
  sel_e              sel;
  logic [CIDX_W-1:0] idx;
  logic              word_ok;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CTL_W];

  always_comb begin
    sel     = SEL_NONE;
    idx     = addr[2 +: CIDX_W];
    word_ok = (addr[1:0] == 2'b00) && (int'(addr[3:2]) < NUM_CORES);
    if (addr == OFS_SHARED) sel = SEL_SHARED;
    else if (addr == OFS_LTROUTE) sel = SEL_LTROUTE;
    else if (word_ok) begin
      if (addr[ADDR_W-1:4] == OFS_TMRCTL[ADDR_W-1:4]) sel = SEL_TMRCTL;
      else if (addr[ADDR_W-1:4] == OFS_MBXCTL[ADDR_W-1:4]) sel = SEL_MBXCTL;
      else if (addr[ADDR_W-1:4] == OFS_IRQSRC[ADDR_W-1:4]) sel = SEL_IRQSRC;
      else if (addr[ADDR_W-1:4] == OFS_FIQSRC[ADDR_W-1:4]) sel = SEL_FIQSRC;
    end
  end

  always_comb begin
    case (sel)
      SEL_SHARED:  rd_mux = DATA_W'({up_fiq_core_q, up_irq_core_q});
      SEL_LTROUTE: rd_mux = DATA_W'({lt_fiq_q, lt_core_q});
      SEL_TMRCTL:  rd_mux = DATA_W'(tmr_ctl_q[idx]);
      SEL_MBXCTL:  rd_mux = DATA_W'(mbx_ctl_q[idx]);
      SEL_IRQSRC:  rd_mux = DATA_W'(irq_src_i[idx]);
      SEL_FIQSRC:  rd_mux = DATA_W'(fiq_src_i[idx]);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_ctl_q     <= '0;
      mbx_ctl_q     <= '0;
      up_irq_core_q <= '0;
      up_fiq_core_q <= '0;
      lt_core_q     <= '0;
      lt_fiq_q      <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_SHARED: begin
          up_irq_core_q <= wdata[CIDX_W-1:0];
          up_fiq_core_q <= wdata[2*CIDX_W-1:CIDX_W];
        end
        SEL_LTROUTE: begin
          lt_core_q <= wdata[CIDX_W-1:0];
          lt_fiq_q  <= wdata[CIDX_W];
        end
        SEL_TMRCTL: tmr_ctl_q[idx] <= wdata[CTL_W-1:0];
        SEL_MBXCTL: mbx_ctl_q[idx] <= wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata         = rdata_q;
  assign rd_valid      = rd_valid_q;
  assign tmr_ctl_o     = tmr_ctl_q;
  assign mbx_ctl_o     = mbx_ctl_q;
  assign up_irq_core_o = up_irq_core_q;
  assign up_fiq_core_o = up_fiq_core_q;
  assign lt_core_o     = lt_core_q;
  assign lt_fiq_o      = lt_fiq_q;

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0));
  // R6
  src_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_IRQSRC || sel == SEL_FIQSRC || sel == SEL_NONE)) |=>
      ($stable(tmr_ctl_q) && $stable(mbx_ctl_q) && $stable(up_irq_core_q) &&
       $stable(up_fiq_core_q) && $stable(lt_core_q) && $stable(lt_fiq_q)));
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CIDX_W   = $clog2(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic                       reg_rd_en,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       reg_rd_valid,
  input  logic [NUM_CORES*N_TMR-1:0] tmr_lvl,
  input  logic [NUM_CORES*N_MBX-1:0] mbx_lvl,
  input  logic                       up_irq,
  input  logic                       up_fiq,
  input  logic                       ltmr_req,
  output logic [NUM_CORES-1:0]       core_irq,
  output logic [NUM_CORES-1:0]       core_fiq
);
  logic [NUM_CORES-1:0][SRC_W-1:0] irq_src, fiq_src;
  logic [NUM_CORES-1:0][CTL_W-1:0] tmr_ctl, mbx_ctl;
  logic [CIDX_W-1:0] up_irq_core, up_fiq_core, lt_core;
  logic              lt_fiq;
  logic [NUM_CORES-1:0] up_irq_hit, up_fiq_hit, lt_irq_hit, lt_fiq_hit;

  irq_steer_regs #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rd_valid(reg_rd_valid),
    .irq_src_i(irq_src), .fiq_src_i(fiq_src),
    .tmr_ctl_o(tmr_ctl), .mbx_ctl_o(mbx_ctl),
    .up_irq_core_o(up_irq_core), .up_fiq_core_o(up_fiq_core),
    .lt_core_o(lt_core), .lt_fiq_o(lt_fiq)
  );

  irq_steer_fanout #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_fanout (
    .clk(clk), .rst_n(rst_n),
    .up_irq(up_irq), .up_fiq(up_fiq), .ltmr_req(ltmr_req),
    .up_irq_core(up_irq_core), .up_fiq_core(up_fiq_core),
    .lt_core(lt_core), .lt_fiq(lt_fiq),
    .up_irq_hit(up_irq_hit), .up_fiq_hit(up_fiq_hit),
    .lt_irq_hit(lt_irq_hit), .lt_fiq_hit(lt_fiq_hit)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    irq_steer_core u_core (
      .clk(clk), .rst_n(rst_n),
      .tmr_lvl(tmr_lvl[c*N_TMR +: N_TMR]),
      .mbx_lvl(mbx_lvl[c*N_MBX +: N_MBX]),
      .tmr_ctl(tmr_ctl[c]), .mbx_ctl(mbx_ctl[c]),
      .up_irq_hit(up_irq_hit[c]), .up_fiq_hit(up_fiq_hit[c]),
      .lt_irq_hit(lt_irq_hit[c]), .lt_fiq_hit(lt_fiq_hit[c]),
      .irq_src(irq_src[c]), .fiq_src(fiq_src[c]),
      .irq(core_irq[c]), .fiq(core_fiq[c])
    );
  end
endmodule

// File: tb/irq_steer_top_tb.sv
module irq_steer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rd_valid;
  logic [15:0] tmr_lvl = '0, mbx_lvl = '0;
  logic        up_irq = 1'b0, up_fiq = 1'b0, ltmr_req = 1'b0;
  logic [3:0]  core_irq, core_fiq;

  int checks = 0, errors = 0;
  bit done = 0;
  int tctl [4] = '{default: 0};
  int mctl [4] = '{default: 0};
  int shr = 0, ltr = 0;

  always #4 clk = ~clk;

  irq_steer_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid), .tmr_lvl(tmr_lvl), .mbx_lvl(mbx_lvl),
    .up_irq(up_irq), .up_fiq(up_fiq), .ltmr_req(ltmr_req),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_src(input int c, input bit fq);
    logic [31:0] v = 0;
    for (int j = 0; j < 4; j++) begin
      bit ie = tctl[c][j], fe = tctl[c][j+4];
      if (tmr_lvl[c*4+j] && (fq ? fe : (ie && !fe))) v[j] = 1'b1;
      ie = mctl[c][j]; fe = mctl[c][j+4];
      if (mbx_lvl[c*4+j] && (fq ? fe : (ie && !fe))) v[4+j] = 1'b1;
    end
    if (!fq && up_irq && (shr % 4) == c) v[8] = 1'b1;
    if (fq && up_fiq && ((shr / 4) % 4) == c) v[8] = 1'b1;
    if (ltmr_req && (ltr % 4) == c && ((ltr / 4) == (fq ? 1 : 0))) v[11] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] mread(input int a);
    if (a % 4 != 0) return 0;
    if (a == 'h0C) return shr;
    if (a == 'h24) return ltr;
    if (a >= 'h40 && a < 'h50) return tctl[(a-'h40)/4];
    if (a >= 'h50 && a < 'h60) return mctl[(a-'h50)/4];
    if (a >= 'h60 && a < 'h70) return exp_src((a-'h60)/4, 0);
    if (a >= 'h70 && a < 'h80) return exp_src((a-'h70)/4, 1);
    return 0;
  endfunction

  function automatic void mwrite(input int a, input logic [31:0] d);
    if (a % 4 != 0) return;
    if (a == 'h0C) shr = int'(d & 32'hF);
    else if (a == 'h24) ltr = int'(d & 32'h7);
    else if (a >= 'h40 && a < 'h50) tctl[(a-'h40)/4] = int'(d & 32'hFF);
    else if (a >= 'h50 && a < 'h60) mctl[(a-'h50)/4] = int'(d & 32'hFF);
  endfunction

  // R7: per-cycle comparison of core outputs against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [3:0] ei, ef;
      for (int c = 0; c < 4; c++) begin
        ei[c] = (exp_src(c, 0) != 0);
        ef[c] = (exp_src(c, 1) != 0);
      end
      chk("R7 core_irq", 32'(core_irq), 32'(ei));
      chk("R7 core_fiq", 32'(core_fiq), 32'(ef));
    end
  end

  task automatic set_in(input logic [15:0] t, input logic [15:0] m,
                        input logic ui, input logic uf, input logic lt);
    @(negedge clk);
    tmr_lvl = t; mbx_lvl = m; up_irq = ui; up_fiq = uf; ltmr_req = lt;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'(a); reg_wdata = d;
    @(posedge clk);
    mwrite(a, d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 8'(a);
    e = mread(a);
    @(posedge clk);
    #2;
    chk({tag, " rd_valid"}, 32'(reg_rd_valid), 32'd1);
    chk({tag, " rdata"}, reg_rdata, e);
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic rdx(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 8'(a);
    @(posedge clk);
    #2;
    chk(tag, reg_rdata, e);
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog act=running exp=finished");
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs and read data quiet in reset
    chk("R1 irq in reset", 32'(core_irq), 0);
    chk("R1 rdata in reset", reg_rdata, 0);
    rst_n = 1'b1;
    rdx('h0C, 0, "R1 shared route"); rdx('h24, 0, "R1 lt route");
    for (int c = 0; c < 4; c++) begin
      rdx('h40 + 4*c, 0, "R1 tmr ctl"); rdx('h50 + 4*c, 0, "R1 mbx ctl");
    end
    // R2: timer steering on core 0, all four lines high
    set_in(16'h000F, 0, 0, 0, 0);
    wr('h40, 'h0F); rdx('h60, 'h00F, "R2 irq only"); rdx('h70, 0, "R2 irq only fiq");
    wr('h40, 'hF0); rdx('h60, 0, "R2 fiq only irq"); rdx('h70, 'h00F, "R2 fiq only");
    wr('h40, 'hFF); rdx('h60, 0, "R2 both irq"); rdx('h70, 'h00F, "R2 both fiq");
    wr('h40, 'h00); rdx('h60, 0, "R2 masked irq"); rdx('h70, 0, "R2 masked fiq");
    wr('h40, 'h3C); rdx('h60, 'h00C, "R2 split irq"); rdx('h70, 'h003, "R2 split fiq");
    // R2: core 2 lines 0 and 2
    set_in(16'h0500, 0, 0, 0, 0);
    wr('h48, 'h41); rdx('h68, 'h001, "R2 core2 irq"); rdx('h78, 'h004, "R2 core2 fiq");
    // R3: mailboxes of core 3
    set_in(0, 16'hF000, 0, 0, 0);
    wr('h5C, 'hF0); rdx('h7C, 'h0F0, "R3 mbx fiq"); rdx('h6C, 0, "R3 mbx irq");
    wr('h5C, 'h06); rdx('h6C, 'h060, "R3 mbx split");
    // R4: shared route
    set_in(0, 0, 1, 1, 0);
    wr('h0C, 'h9); rdx('h0C, 'h9, "R4 route read");
    rdx('h64, 'h100, "R4 irq core1"); rdx('h78, 'h100, "R4 fiq core2");
    rdx('h60, 0, "R4 no broadcast");
    wr('h0C, 32'hFFFF_FFF6); rdx('h0C, 'h6, "R4 packed read");
    // R5: local timer
    set_in(0, 0, 0, 0, 1);
    wr('h24, 'h5); rdx('h74, 'h800, "R5 fiq core1"); rdx('h64, 0, "R5 not irq");
    wr('h24, 'h3); rdx('h6C, 'h800, "R5 irq core3");
    wr('h24, 'hFF); rdx('h24, 'h7, "R5 3 bits");
    // R6: source registers ignore writes
    set_in(16'h000F, 0, 0, 0, 0);
    wr('h40, 'h0F); wr('h60, 'hFFF); wr('h74, 'hFFF);
    rdx('h60, 'h00F, "R6 src ignore"); rdx('h74, 0, "R6 src ignore fiq");
    // R8: 8-bit control registers
    wr('h44, 32'hFFFF_FFFF); rdx('h44, 'hFF, "R8 tmr ctl width");
    wr('h54, 32'h1234_5678); rdx('h54, 'h78, "R8 mbx ctl width");
    // R9: unmapped and misaligned
    rdx('h90, 0, "R9 unmapped"); rdx('h04, 0, "R9 unmapped low");
    rdx('h42, 0, "R9 misaligned"); rdx('hC0, 0, "R9 high");
    wr('h90, 32'hFFFF); wr('h42, 'hFF); wr('h0D, 'hF);
    rdx('h40, 'h0F, "R9 write ignored"); rdx('h0C, 'h6, "R9 route kept");
    // mixed random phase, all requirements against the model
    for (int it = 0; it < 400; it++) begin
      int pick, a;
      set_in(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      pick = $urandom_range(0, 19);
      case (pick)
        0: a = 'h0C; 1: a = 'h24; 2: a = 'h90; 3: a = 'h04; 4: a = 'h41;
        default: a = 'h40 + 4 * (pick - 5);
      endcase
      wr(a, $urandom);
      rd('h40 + 4 * $urandom_range(0, 15), "R10 random");
      rd(pick < 5 ? a : 'h60 + 4 * $urandom_range(0, 7), "R10 random");
    end
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule